// File: doc/BRIEF.md
# Brightness fade sequencer

This block produces the current code for the main LED group of a backlight controller. Software writes a target code and a fade rate; the block either moves its output straight to the target or walks it there one code at a time, with each step spaced a programmable number of millisecond ticks apart. A busy flag tells the surrounding logic that a walk is still under way.

A walk can be bent toward a new target or sped up or slowed down while it runs, and it can be cut short by turning fading off, which lands the output on the target at once. Fading only happens while at least one LED output is enabled; otherwise the output tracks the target directly. Other LED groups bypass this block, and the conversion of the code into an analog current happens elsewhere.

Top module: `brightness_fader`

## Requirements
- R1: After reset the output code is 0, the stored target is 0, fading is off (rate code 00) and busy is low.
- R2: The 2-bit rate code selects the fade: 00 means no fading, 01 means one step per 8 ticks, 10 one step per 16 ticks, 11 one step per 32 ticks; the output changes only in the cycle after a tick, never between ticks.
- R3: While fading, each step moves the output by exactly one code toward the target, so a walk from code A to code B produces exactly |A-B| output changes.
- R4: With rate code 00, a target write puts the new code on the output one cycle after the write, with busy low.
- R5: A target write during a walk redirects the walk toward the new target starting from the present output code.
- R6: Writing a new nonzero rate during a walk restarts the step timer and continues the walk at the new rate; the next step comes a full new period after the write.
- R7: Writing rate code 00 during a walk puts the target on the output one cycle after the write, with busy low.
- R8: While the any-LED-enabled input is low no walk runs: the output equals the target one cycle after any write, and dropping the input mid-walk puts the target on the output in the next cycle.
- R9: Busy is high exactly while the output code differs from the stored target; while busy is low and nothing is written the output does not change.
- R10: A target write restarts the step timer, so the first step of a walk comes a full period after the write no matter how many ticks arrived before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_wr | input | 1 | One-cycle write strobe for the main target code |
| tgt_code | input | CODE_W | Target code carried with tgt_wr |
| rate_wr | input | 1 | One-cycle write strobe for the fade rate |
| rate_code | input | RATE_W | Rate code carried with rate_wr |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| any_led_en | input | 1 | High while any LED output is enabled |
| level | output | CODE_W | Present current code of the main group |
| busy | output | 1 | High while a walk toward the target is pending |

## Verification
The bench goes after tick counting at each rate, checking the output one tick before and exactly on the step boundary; a timer that was not restarted by a write or rate change would step early after idle ticks. It redirects a walk in the middle and expects the next code to be one away from the present code, which a design that restarted from the old start point would miss. It cancels a walk by writing rate 00 and drops the LED-enable input mid-walk, where a design that ignored either would keep stepping instead of landing on the target. A scoreboard of expected code changes catches any skipped or doubled step.

// File: rtl/fade_seq_pkg.sv
package fade_seq_pkg;
   // Ticks per step for a rate code; code 0 means fading is off.
   function automatic int unsigned step_period(input int unsigned sel,
                                               input int unsigned base);
      return (sel == 0) ? 0 : (base << (sel - 1));
   endfunction
endpackage

// File: rtl/fade_step_timer.sv
module fade_step_timer
   import fade_seq_pkg::*;
#(
   parameter int unsigned RATE_W     = 2,
   parameter int unsigned BASE_TICKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              step
);
   localparam int unsigned MAX_PER = BASE_TICKS << ((1 << RATE_W) - 2);
   localparam int unsigned CNT_W   = $clog2(MAX_PER);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic             at_last;

   always_comb begin
      last_cnt = CNT_W'(step_period(32'(rate_sel), BASE_TICKS) - 1);
      at_last  = (cnt_q == last_cnt);
      step     = run && tick && !restart && at_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart || !run)  cnt_q <= '0;
      else if (tick)             cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/fade_level_step.sv
module fade_level_step #(
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jump,
   input  logic [CODE_W-1:0] jump_code,
   input  logic              step,
   input  logic [CODE_W-1:0] goal,
   output logic [CODE_W-1:0] level
);
   always_ff @(posedge clk) begin
      if (!rst_n)     level <= '0;
      else if (jump)  level <= jump_code;
      else if (step) begin
         if (level < goal)       level <= level + 1'b1;
         else if (level > goal)  level <= level - 1'b1;
      end
   end
endmodule

// File: rtl/brightness_fader.sv
module brightness_fader #(
   parameter int unsigned CODE_W     = 5,
   parameter int unsigned RATE_W     = 2,
   parameter int unsigned BASE_TICKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_wr,
   input  logic [CODE_W-1:0] tgt_code,
   input  logic              rate_wr,
   input  logic [RATE_W-1:0] rate_code,
   input  logic              ms_tick,
   input  logic              any_led_en,
   output logic [CODE_W-1:0] level,
   output logic              busy
);
   generate
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
         $error("brightness_fader: CODE_W out of range");
      end
      if (RATE_W < 1 || RATE_W > 3) begin : g_bad_rate
         $error("brightness_fader: RATE_W out of range");
      end
      if (BASE_TICKS < 2) begin : g_bad_base
         $error("brightness_fader: BASE_TICKS must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] tgt_q, tgt_nxt;
   logic [RATE_W-1:0] rate_q, rate_nxt;
   logic              fade_nxt;
   logic              run;
   logic              step;

   always_comb begin
      tgt_nxt  = tgt_wr  ? tgt_code  : tgt_q;
      rate_nxt = rate_wr ? rate_code : rate_q;
      fade_nxt = (rate_nxt != '0) && any_led_en;
      busy     = (level != tgt_q);
      run      = (rate_q != '0) && any_led_en && busy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         rate_q <= '0;
      end else begin
         tgt_q  <= tgt_nxt;
         rate_q <= rate_nxt;
      end
   end

   fade_step_timer #(.RATE_W(RATE_W), .BASE_TICKS(BASE_TICKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (tgt_wr || rate_wr),
      .run      (run),
      .tick     (ms_tick),
      .rate_sel (rate_q),
      .step     (step)
   );

   fade_level_step #(.CODE_W(CODE_W)) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .jump      (!fade_nxt),
      .jump_code (tgt_nxt),
      .step      (step),
      .goal      (tgt_q),
      .level     (level)
   );
endmodule

// File: rtl/brightness_fader_chk.sv
module brightness_fader_chk #(
   parameter int unsigned CODE_W = 5,
   parameter int unsigned RATE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tgt_wr,
   input logic [CODE_W-1:0] tgt_code,
   input logic              rate_wr,
   input logic [RATE_W-1:0] rate_code,
   input logic              ms_tick,
   input logic              any_led_en,
   input logic [CODE_W-1:0] level,
   input logic              busy,
   input logic [RATE_W-1:0] rate_q
);
   assert_tick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ms_tick && !tgt_wr && !rate_wr && any_led_en && rate_q != '0) |=> $stable(level));

   assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_led_en && rate_q != '0 && !tgt_wr && !rate_wr) |=>
      (level == $past(level) || level == $past(level) + 1'b1 || level == $past(level) - 1'b1));

   assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_wr && !rate_wr && rate_q == '0) |=> (level == $past(tgt_code) && !busy));

   assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_wr && rate_code == '0) |=> !busy);

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !any_led_en |=> !busy);

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !tgt_wr && !rate_wr) |=> $stable(level));
endmodule

bind brightness_fader brightness_fader_chk #(.CODE_W(CODE_W), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/brightness_fader_bench.sv
module brightness_fader_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tgt_wr = 1'b0;
   logic [4:0] tgt_code = '0;
   logic       rate_wr = 1'b0;
   logic [1:0] rate_code = '0;
   logic       ms_tick = 1'b0;
   logic       any_led_en = 1'b0;
   logic [4:0] level;
   logic       busy;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   int exp_q[$];
   logic [4:0] prev_level = '0;

   always #10 clk = ~clk;

   brightness_fader u_brightness_fader (
      .clk(clk), .rst_n(rst_n), .tgt_wr(tgt_wr), .tgt_code(tgt_code),
      .rate_wr(rate_wr), .rate_code(rate_code), .ms_tick(ms_tick),
      .any_led_en(any_led_en), .level(level), .busy(busy));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(input int v);
      exp_q.push_back(v);
   endtask

   task automatic wr_tgt(input int v);
      @(negedge clk); tgt_wr = 1'b1; tgt_code = 5'(v);
      @(negedge clk); tgt_wr = 1'b0;
   endtask

   task automatic wr_rate(input int v);
      @(negedge clk); rate_wr = 1'b1; rate_code = 2'(v);
      @(negedge clk); rate_wr = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ms_tick = 1'b1;
         @(negedge clk); ms_tick = 1'b0;
      end
   endtask

   // Monitor: every change of the output code must match the next expected item (R3).
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (level != prev_level) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected change", int'(level), -1);
            else begin
               automatic int e = exp_q.pop_front();
               chk(int'(level) == e, "R3 scoreboard", int'(level), e);
            end
         end
         prev_level = level;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(level == 0, "R1 reset level", int'(level), 0);
      chk(busy == 0, "R1 reset busy", int'(busy), 0);
      any_led_en = 1'b1;

      // R4 immediate jump with rate 00
      push(20); wr_tgt(20);
      chk(level == 20, "R4 immediate", int'(level), 20);
      chk(busy == 0, "R4 busy low", int'(busy), 0);

      // R2 rate 01: 8 ticks per step, walking down 20->17
      wr_rate(1);
      push(19); push(18); push(17); wr_tgt(17);
      chk(busy == 1, "R9 busy during walk", int'(busy), 1);
      tick(7);
      chk(level == 20, "R2 before 8th tick", int'(level), 20);
      tick(1);
      chk(level == 19, "R2 on 8th tick", int'(level), 19);
      tick(16);
      chk(level == 17, "R3 walk end", int'(level), 17);
      chk(busy == 0, "R9 busy clears", int'(busy), 0);

      // R10 idle ticks do not shorten the first period
      tick(5);
      chk(level == 17, "R9 idle stable", int'(level), 17);
      push(18); wr_tgt(20);
      tick(7);
      chk(level == 17, "R10 no early step", int'(level), 17);
      tick(1);
      chk(level == 18, "R10 first step", int'(level), 18);

      // R5 redirect from present code 18 toward 15
      push(17); push(16); push(15); wr_tgt(15);
      tick(8);
      chk(level == 17, "R5 redirect from present", int'(level), 17);
      tick(8);
      chk(level == 16, "R5 second step", int'(level), 16);

      // R6 new rate 10 mid-walk
      wr_rate(2);
      tick(15);
      chk(level == 16, "R6 before 16th tick", int'(level), 16);
      tick(1);
      chk(level == 15, "R6 on 16th tick", int'(level), 15);

      // R7 cancel mid-walk
      push(16); push(17); wr_tgt(25);
      tick(32);
      chk(level == 17, "R7 walk progress", int'(level), 17);
      push(25); wr_rate(0);
      chk(level == 25, "R7 jump to target", int'(level), 25);
      chk(busy == 0, "R7 busy low", int'(busy), 0);

      // R8 no walk while LEDs disabled
      wr_rate(3);
      @(negedge clk); any_led_en = 1'b0;
      push(3); wr_tgt(3);
      chk(level == 3, "R8 immediate when disabled", int'(level), 3);
      chk(busy == 0, "R8 busy low", int'(busy), 0);
      @(negedge clk); any_led_en = 1'b1;

      // R2 rate 11: 32 ticks per step
      push(4); push(5); push(6); wr_tgt(6);
      tick(31);
      chk(level == 3, "R2 before 32nd tick", int'(level), 3);
      tick(1);
      chk(level == 4, "R2 on 32nd tick", int'(level), 4);
      tick(64);
      chk(level == 6, "R3 walk up end", int'(level), 6);

      // R8 enable drop mid-walk
      push(5); push(4); wr_tgt(0);
      tick(64);
      chk(level == 4, "R8 walk before drop", int'(level), 4);
      push(0);
      @(negedge clk); any_led_en = 1'b0;
      @(negedge clk);
      chk(level == 0, "R8 drop lands on target", int'(level), 0);
      chk(busy == 0, "R8 busy after drop", int'(busy), 0);

      @(negedge clk);
      chk(exp_q.size() == 0, "R3 all changes seen", exp_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule